// File: doc/BRIEF.md
# I2C Bus Status and Arbitration Monitor

This block observes the clock and data lines of a two-wire I2C bus next to the local bus controller and keeps an 8-bit status word up to date. It finds START and STOP conditions, counts the clock pulses of every byte, compares the address byte that follows a START with a programmed own address, and records the acknowledge level, the direction requested by the calling master and the state of the bus. It does not drive the lines, generate the clock or shift data. It only reports what happened, so the controller can react.

The controller gives the block its intended SDA level, whether it acts as master or slave, whether it transmits or receives, and its START, repeated-START and STOP requests. From these the monitor raises a sticky arbitration-lost flag in five situations. A sticky pending flag marks byte completion, an own-address match in slave-receive mode and lost arbitration. The interrupt output shows that pending flag while interrupts are enabled. Software clears the two sticky flags by writing zero to them and clears the addressed flag through any control-register write.

Top module: `i2c_stat_mon`

## Requirements
- R1: After reset `status_o` reads 0x80. The bit map is 7 = transfer complete, 6 = addressed as slave, 5 = bus busy, 4 = arbitration lost, 3 = always 0, 2 = slave direction, 1 = pending, 0 = received acknowledge.
- R2: SDA falling while SCL stays high is a START and sets bit 5. SDA rising while SCL stays high is a STOP and clears bit 5.
- R3: Bit 7 clears at the SCL rising edge of the first bit of a byte. It sets at the SCL falling edge that ends the ninth clock.
- R4: Bit 6 sets when the 7 bits after a START equal `own_addr_i` while slave mode is selected. The match is evaluated at the rising edge of the eighth bit. A pulse on `ctrl_wr_i` clears bit 6.
- R5: On a match, bit 2 takes the eighth bit of the byte: 1 means the master reads and 0 means the master writes.
- R6: Bit 0 takes the SDA level at the rising edge of the ninth clock: 0 means acknowledged and 1 means not acknowledged.
- R7: As transmitting master, an SCL rising edge of one of the first eight bits with `sda_drv_i`=1 and SDA low sets bit 4. With `sda_drv_i`=0 it does not.
- R8: As receiving master, the ninth-clock rising edge with `sda_drv_i`=1 and SDA low sets bit 4. The first eight bits of a received byte never set it.
- R9: A pulse on `start_req_i` while bit 5 is set sets bit 4. While bit 5 is clear it has no effect.
- R10: A pulse on `rstart_req_i` in slave mode sets bit 4. In master mode it has no effect.
- R11: A STOP seen in master mode while `stop_req_i` is 0 sets bit 4. A STOP seen while `stop_req_i` is 1, or in slave mode, does not.
- R12: Bit 1 sets on byte completion, on a match with bit 2 = 0 and on any event that sets bit 4. `irq_o` is 1 exactly when bit 1 and `irq_en_i` are both 1.
- R13: A pulse on `sw_wr_i` clears bit 4 when `sw_al_i` is 0 and bit 1 when `sw_pend_i` is 0. A value of 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| sda_drv_i | input | 1 | SDA level the local controller intends (1 = released high) |
| is_master_i | input | 1 | 1 = master mode, 0 = slave mode |
| is_tx_i | input | 1 | 1 = transmit, 0 = receive |
| start_req_i | input | 1 | One-cycle START request |
| rstart_req_i | input | 1 | One-cycle repeated-START request |
| stop_req_i | input | 1 | Level: controller has requested a STOP |
| own_addr_i | input | 7 | Own slave address |
| irq_en_i | input | 1 | Interrupt enable |
| ctrl_wr_i | input | 1 | Control-register write strobe |
| sw_wr_i | input | 1 | Status-register write strobe |
| sw_al_i | input | 1 | Value written to the arbitration-lost flag |
| sw_pend_i | input | 1 | Value written to the pending flag |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
Every result is registered one clock edge after the input change that causes it. A line edge, a START, a STOP, a request pulse or a software write that is applied between clock edges appears in `status_o` after the next rising clock edge. `irq_o` follows the pending bit in the same cycle. The bench changes inputs on the falling clock edge, holds them through one rising edge and samples on the following falling edge. In this way each check sees the cycle in which the flag is due, including the match that comes before the ninth clock and the completion after its fall.

// File: rtl/i2c_stat_pkg.sv
`timescale 1ns/1ps
package i2c_stat_pkg;

    localparam int ST_W   = 8;
    localparam int B_TCF  = 7;
    localparam int B_AAS  = 6;
    localparam int B_BUSY = 5;
    localparam int B_ARBL = 4;
    localparam int B_RSV  = 3;
    localparam int B_SRW  = 2;
    localparam int B_PEND = 1;
    localparam int B_RACK = 0;

    // field order equals the bit map of the status word
    typedef struct packed {
        logic tcf;
        logic aas;
        logic busy;
        logic arbl;
        logic rsv;
        logic srw;
        logic pend;
        logic rack;
    } stat_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic data_rise;   // rising SCL of one of the byte's data bits
        logic ack_rise;    // rising SCL of the ninth clock
        logic first_rise;  // rising SCL of the byte's first bit
        logic byte_done;   // falling SCL ending the ninth clock
        logic match;       // own address recognised
        logic bit_val;     // SDA at this rising edge
    } byte_ev_t;

    function automatic stat_t stat_reset();
        stat_t s;
        s     = '0;
        s.tcf = 1'b1;
        return s;
    endfunction

    // sticky flag: keep unless a software write stores zero
    function automatic logic sw_keep(input logic cur, input logic wr, input logic val);
        return cur & ~(wr & ~val);
    endfunction

endpackage

// File: rtl/i2c_line_events.sv
`timescale 1ns/1ps
module i2c_line_events
    import i2c_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.scl_rise = scl_i & ~scl_q;
        ev.scl_fall = ~scl_i & scl_q;
        ev.start    = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2c_byte_track.sv
`timescale 1ns/1ps
module i2c_byte_track
    import i2c_stat_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              sda_i,
    input  logic              is_master_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output byte_ev_t          bev
);

    localparam int BYTE_BITS = ADDR_W + 1;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_BITS - 1);

    logic [CNT_W-1:0]  cnt;      // completed clocks of the current byte
    logic              hi;       // a rising edge belongs to the current bit
    logic              addr_ph;  // first byte after START
    logic [ADDR_W-1:0] sh;

    always_comb begin
        bev.data_rise  = ev.scl_rise && (cnt < ACK_IDX);
        bev.ack_rise   = ev.scl_rise && (cnt == ACK_IDX);
        bev.first_rise = ev.scl_rise && (cnt == '0);
        bev.byte_done  = ev.scl_fall && hi && (cnt == ACK_IDX);
        bev.match      = ev.scl_rise && (cnt == LAST_IDX) && addr_ph
                         && !is_master_i && (sh == own_addr_i);
        bev.bit_val    = sda_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            hi      <= 1'b0;
            addr_ph <= 1'b0;
            sh      <= '0;
        end else if (ev.start || ev.stop) begin
            cnt     <= '0;
            hi      <= 1'b0;
            addr_ph <= ev.start;
        end else begin
            if (ev.scl_rise) begin
                hi <= 1'b1;
                if (bev.data_rise)
                    sh <= {sh[ADDR_W-2:0], sda_i};
            end
            if (ev.scl_fall && hi) begin
                hi <= 1'b0;
                if (cnt == ACK_IDX) begin
                    cnt     <= '0;
                    addr_ph <= 1'b0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/i2c_stat_reg.sv
`timescale 1ns/1ps
module i2c_stat_reg
    import i2c_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  byte_ev_t bev,
    input  logic     start_det,
    input  logic     stop_det,
    input  logic     sda_drv_i,
    input  logic     is_master_i,
    input  logic     is_tx_i,
    input  logic     start_req_i,
    input  logic     rstart_req_i,
    input  logic     stop_req_i,
    input  logic     ctrl_wr_i,
    input  logic     sw_wr_i,
    input  logic     sw_al_i,
    input  logic     sw_pend_i,
    output stat_t    st
);

    stat_t st_n;
    logic  lost_tx, lost_ack, lost_start, lost_rstart, lost_stop, lost_any;

    always_comb begin
        lost_tx     = is_master_i && is_tx_i && bev.data_rise && sda_drv_i && !bev.bit_val;
        lost_ack    = is_master_i && !is_tx_i && bev.ack_rise && sda_drv_i && !bev.bit_val;
        lost_start  = start_req_i && st.busy;
        lost_rstart = rstart_req_i && !is_master_i;
        lost_stop   = stop_det && is_master_i && !stop_req_i;
        lost_any    = lost_tx | lost_ack | lost_start | lost_rstart | lost_stop;
    end

    always_comb begin
        st_n = st;
        if (bev.first_rise) st_n.tcf = 1'b0;
        if (bev.byte_done)  st_n.tcf = 1'b1;

        if (ctrl_wr_i) st_n.aas = 1'b0;
        if (bev.match) begin
            st_n.aas = 1'b1;
            st_n.srw = bev.bit_val;
        end

        if (start_det) st_n.busy = 1'b1;
        if (stop_det)  st_n.busy = 1'b0;

        st_n.arbl = sw_keep(st.arbl, sw_wr_i, sw_al_i) | lost_any;
        st_n.pend = sw_keep(st.pend, sw_wr_i, sw_pend_i) | lost_any | bev.byte_done
                    | (bev.match && !bev.bit_val);

        if (bev.ack_rise) st_n.rack = bev.bit_val;
        st_n.rsv = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= stat_reset();
        else     st <= st_n;
    end

endmodule

// File: rtl/i2c_stat_mon.sv
`timescale 1ns/1ps
module i2c_stat_mon
    import i2c_stat_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              sda_drv_i,
    input  logic              is_master_i,
    input  logic              is_tx_i,
    input  logic              start_req_i,
    input  logic              rstart_req_i,
    input  logic              stop_req_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              irq_en_i,
    input  logic              ctrl_wr_i,
    input  logic              sw_wr_i,
    input  logic              sw_al_i,
    input  logic              sw_pend_i,
    output logic [ST_W-1:0]   status_o,
    output logic              irq_o
);

    line_ev_t lev;
    byte_ev_t bev;
    stat_t    st;

    i2c_line_events u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (lev)
    );

    i2c_byte_track #(.ADDR_W(ADDR_W)) u_byte (
        .clk         (clk),
        .rst         (rst),
        .ev          (lev),
        .sda_i       (sda_i),
        .is_master_i (is_master_i),
        .own_addr_i  (own_addr_i),
        .bev         (bev)
    );

    i2c_stat_reg u_stat (
        .clk          (clk),
        .rst          (rst),
        .bev          (bev),
        .start_det    (lev.start),
        .stop_det     (lev.stop),
        .sda_drv_i    (sda_drv_i),
        .is_master_i  (is_master_i),
        .is_tx_i      (is_tx_i),
        .start_req_i  (start_req_i),
        .rstart_req_i (rstart_req_i),
        .stop_req_i   (stop_req_i),
        .ctrl_wr_i    (ctrl_wr_i),
        .sw_wr_i      (sw_wr_i),
        .sw_al_i      (sw_al_i),
        .sw_pend_i    (sw_pend_i),
        .st           (st)
    );

    assign status_o = st;
    assign irq_o    = st.pend & irq_en_i;

endmodule

// File: rtl/i2c_stat_mon_chk.sv
`timescale 1ns/1ps
module i2c_stat_mon_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_i,
    input logic       start_req_i,
    input logic       sw_wr_i,
    input logic       sw_al_i,
    input logic [7:0] status_o
);

    logic seen, scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            seen  <= 1'b1;
            scl_d <= scl_i;
            sda_d <= sda_i;
        end
    end

    a_r1_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        status_o[3] == 1'b0);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (seen && scl_i && scl_d && sda_d && !sda_i) |=> status_o[5]);

    a_r9_start_when_busy: assert property (@(posedge clk) disable iff (rst)
        (start_req_i && status_o[5]) |=> status_o[4]);

    a_r13_lost_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_o[4] && !(sw_wr_i && !sw_al_i)) |=> status_o[4]);

    a_r12_lost_pends: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[4]) |-> status_o[1]);

endmodule

bind i2c_stat_mon i2c_stat_mon_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .start_req_i (start_req_i),
    .sw_wr_i     (sw_wr_i),
    .sw_al_i     (sw_al_i),
    .status_o    (status_o)
);

// File: tb/i2c_stat_mon_tb.sv
`timescale 1ns/1ps
module i2c_stat_mon_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1, sda = 1'b1, drv = 1'b1;
    logic       master = 1'b0, tx = 1'b0;
    logic       start_req = 1'b0, rstart_req = 1'b0, stop_req = 1'b0;
    logic [6:0] own = 7'h5A;
    logic       irq_en = 1'b0, ctrl_wr = 1'b0;
    logic       sw_wr = 1'b0, sw_al = 1'b0, sw_pend = 1'b0;
    logic [7:0] status;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    i2c_stat_mon dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .sda_drv_i(drv),
        .is_master_i(master), .is_tx_i(tx), .start_req_i(start_req),
        .rstart_req_i(rstart_req), .stop_req_i(stop_req), .own_addr_i(own),
        .irq_en_i(irq_en), .ctrl_wr_i(ctrl_wr), .sw_wr_i(sw_wr),
        .sw_al_i(sw_al), .sw_pend_i(sw_pend), .status_o(status), .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_bus(input logic c, input logic d);
        @(negedge clk); scl = c; sda = d;
        @(negedge clk);
    endtask

    task automatic start_cond();
        set_bus(1, 1); set_bus(1, 0); set_bus(0, 0);
    endtask

    task automatic stop_cond();
        set_bus(0, 0); set_bus(1, 0); set_bus(1, 1);
    endtask

    task automatic bit_rise(input logic b);
        set_bus(0, b); set_bus(1, b);
    endtask

    task automatic bit_fall();
        set_bus(0, sda);
    endtask

    task automatic sw_write(input logic al, input logic pd);
        @(negedge clk); sw_wr = 1; sw_al = al; sw_pend = pd;
        @(negedge clk); sw_wr = 0;
    endtask

    task automatic ctrl_pulse();
        @(negedge clk); ctrl_wr = 1;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1;
        @(negedge clk); start_req = 0;
    endtask

    task automatic pulse_rstart();
        @(negedge clk); rstart_req = 1;
        @(negedge clk); rstart_req = 0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset value and reserved bit
        check("R1 reset", status, 8'h80);
        check("R12 irq after reset", {7'b0, irq}, 8'h00);

        // sweep every calling address in both directions, slave mode
        for (int a = 0; a < 128; a++) begin
            for (int rw = 0; rw < 2; rw++) begin
                logic [6:0] av;
                logic       m, r, ack;
                av  = 7'(a);
                r   = rw[0];
                m   = (av == own);
                ack = av[0] ^ r;
                ctrl_pulse();
                sw_write(0, 0);
                check("R4 cleared by control write", {7'b0, status[6]}, 8'h00);
                start_cond();
                check("R2 busy after START", {7'b0, status[5]}, 8'h01);
                for (int i = 6; i >= 0; i--) begin
                    bit_rise(av[i]);
                    if (i == 6) check("R3 cleared at first bit", {7'b0, status[7]}, 8'h00);
                    bit_fall();
                end
                bit_rise(r);
                check("R4 address match", {7'b0, status[6]}, {7'b0, m});
                check("R12 pending on slave-receive match", {7'b0, status[1]}, {7'b0, m & ~r});
                if (m) check("R5 direction captured", {7'b0, status[2]}, {7'b0, r});
                bit_fall();
                bit_rise(ack);
                check("R3 still clear before ninth fall", {7'b0, status[7]}, 8'h00);
                bit_fall();
                check("R3 set at ninth fall", {7'b0, status[7]}, 8'h01);
                check("R12 pending on byte done", {7'b0, status[1]}, 8'h01);
                check("R6 acknowledge level", {7'b0, status[0]}, {7'b0, ack});
                check("R12 irq masked", {7'b0, irq}, 8'h00);
                stop_cond();
                check("R2 idle after STOP", {7'b0, status[5]}, 8'h00);
            end
        end

        // R7 transmitting master
        ctrl_pulse(); sw_write(0, 0);
        master = 1; tx = 1; drv = 0;
        start_cond();
        bit_rise(0);
        check("R7 no loss when driving low", {7'b0, status[4]}, 8'h00);
        bit_fall();
        drv = 1;
        bit_rise(0);
        check("R7 loss on transmit mismatch", {7'b0, status[4]}, 8'h01);
        check("R12 pending on loss", {7'b0, status[1]}, 8'h01);
        irq_en = 1;
        @(negedge clk);
        check("R12 irq when enabled", {7'b0, irq}, 8'h01);
        sw_write(1, 1);
        check("R13 write of ones keeps flags", {6'b0, status[4], status[1]}, 8'h03);
        sw_write(0, 1);
        check("R13 zero clears lost only", {6'b0, status[4], status[1]}, 8'h01);
        sw_write(1, 0);
        check("R13 zero clears pending", {6'b0, status[4], status[1]}, 8'h00);
        check("R12 irq follows pending", {7'b0, irq}, 8'h00);
        bit_fall();
        drv = 0; stop_req = 1;
        stop_cond();
        stop_req = 0;
        check("R11 requested STOP no loss", {7'b0, status[4]}, 8'h00);

        // R8 receiving master
        tx = 0; drv = 1;
        start_cond();
        for (int i = 0; i < 8; i++) begin bit_rise(0); bit_fall(); end
        check("R8 data bits ignored", {7'b0, status[4]}, 8'h00);
        set_bus(0, 1);
        set_bus(0, 0);
        set_bus(1, 0);
        check("R8 loss at acknowledge", {7'b0, status[4]}, 8'h01);
        bit_fall();
        stop_req = 1; stop_cond(); stop_req = 0;
        sw_write(0, 0);

        // R9 start request
        master = 0;
        pulse_start();
        check("R9 idle start request", {7'b0, status[4]}, 8'h00);
        start_cond();
        pulse_start();
        check("R9 start request while busy", {7'b0, status[4]}, 8'h01);
        sw_write(0, 0);
        stop_cond();

        // R10 repeated start request
        master = 1;
        pulse_rstart();
        check("R10 master repeated start", {7'b0, status[4]}, 8'h00);
        master = 0;
        pulse_rstart();
        check("R10 slave repeated start", {7'b0, status[4]}, 8'h01);
        sw_write(0, 0);

        // R11 unrequested stop
        master = 1;
        start_cond();
        stop_cond();
        check("R11 unrequested STOP", {7'b0, status[4]}, 8'h01);
        check("R12 pending on STOP loss", {7'b0, status[1]}, 8'h01);
        sw_write(0, 0);
        master = 0;
        start_cond();
        stop_cond();
        check("R11 slave STOP no loss", {7'b0, status[4]}, 8'h00);
        check("R1 reserved bit", {7'b0, status[3]}, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule